// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider Pair

This block contains the two counting chains of a frequency synthesizer. The reference chain divides the crystal-derived clock enable by a programmable ratio and emits a one-cycle pulse at each terminal count. The main chain divides the input clock enable by a programmable ratio N. It does this with a two-modulus prescaler that divides by 16 or 17. A swallow counter and a program counter steer the prescaler, and the main chain emits one pulse per N enabled input cycles. Both pulses feed a phase comparator and also serve as monitor outputs.

The whole block runs on one clock. Each chain advances only on its own clock-enable input, so the two enables stand for the crystal clock and the divided input clock. A run input serves as the power-save control. While it is low, both chains hold at their initial count and stay silent. When it returns high, both chains start over together, so their first pulses line up when the two ratios match. A ratio written while a chain is running is taken up only at that chain's next terminal count.

Top module: `psdiv_pair`

## Requirements
- R1: While rst_n is low, ref_pulse, main_pulse, pre_out and mod_hi are all 0.
- R2: With run high, ref_pulse goes high for exactly one clk cycle, in the cycle after the ref_ce-qualified edge that completes every ref_ratio-th enable. After run rises, the first pulse follows the ref_ratio-th enable.
- R3: A ref_ratio value below 5 divides as 5.
- R4: With run high, main_pulse goes high for exactly one clk cycle after every N-th fin_ce-qualified edge, where N is main_ratio. After run rises, the first pulse follows the N-th enable.
- R5: A main_ratio value below 272 (16 × 17) divides as 272.
- R6: main_ratio splits as N = 16·A + B, where A = main_ratio[17:4] and B = main_ratio[3:0]. Within each main period, mod_hi (1 = divide by 17) is high for the first B prescaler cycles and low for the rest. So mod_hi is high for exactly 17·B enabled cycles, and pre_out pulses A times per period, once per prescaler cycle, one clk cycle after the cycle completes.
- R7: While run is low, both chains hold: no ref_pulse, main_pulse or pre_out. When run returns high, both chains restart from zero, so equal ratios give pulses in the same cycle.
- R8: A ratio change takes effect only at the chain's next terminal count. A change applied in the cycle before the completing edge governs the following period, and a change applied later leaves the current period at its old length.
- R9: A chain advances only on clk edges where its enable is high. Enabling on every second cycle doubles the pulse interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 = dividers run, 0 = power-save hold |
| ref_ce | input | 1 | Reference chain count enable (crystal clock tick) |
| fin_ce | input | 1 | Main chain count enable (input clock tick) |
| ref_ratio | input | 17 | Reference division ratio |
| main_ratio | input | 18 | Main division ratio N |
| ref_pulse | output | 1 | Reference terminal-count pulse |
| main_pulse | output | 1 | Main terminal-count pulse |
| pre_out | output | 1 | Prescaler cycle-complete pulse |
| mod_hi | output | 1 | Prescaler modulus select, 1 = divide by 17 |

## Verification
The cycles of concern are those where a ratio update arrives at the edge where a chain completes its count, since the update and the terminal reload both act on that edge. The bench writes a new ratio in the sample just before the completing edge. It expects that pulse to arrive on time and the next interval to take the new length. A write made one cycle after a terminal count must leave the current period at its old length. The same test is run on the main chain, whose terminal edge coincides with a prescaler wrap and a swallow-counter reload.

// File: rtl/psd_pkg.sv
package psd_pkg;
   localparam int PSD_PRE_DIV   = 16;
   localparam int PSD_REF_W     = 17;
   localparam int PSD_MAIN_W    = 18;
   localparam int PSD_REF_MIN   = 5;

   typedef enum logic {
      PSD_MOD_LO = 1'b0,
      PSD_MOD_HI = 1'b1
   } psd_mod_e;
endpackage

// File: rtl/psd_refdiv.sv
module psd_refdiv #(
   parameter int W         = 17,
   parameter int MIN_RATIO = 5,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         ce,
   input  logic [W-1:0] cfg_ratio,
   output logic         pulse_o
);
   localparam logic [W-1:0] MIN_V = W'(MIN_RATIO);

   logic [W-1:0] ratio_eff;
   logic [W-1:0] ratio_act;
   logic [W-1:0] cnt;
   logic         last;
   logic         term;

   assign ratio_eff = (cfg_ratio < MIN_V) ? MIN_V : cfg_ratio;
   assign last      = (cnt == ratio_act - W'(1));
   assign term      = run && ce && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         ratio_act <= MIN_V;
      end else if (!run) begin
         cnt       <= '0;
         ratio_act <= ratio_eff;
      end else if (ce) begin
         if (last) begin
            cnt       <= '0;
            ratio_act <= ratio_eff;
         end else begin
            cnt <= cnt + W'(1);
         end
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= term;
         end
         assign pulse_o = pulse_q;

         // R2
         ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o |=> !pulse_o);
         // R7
         ref_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o |-> $past(run));
      end else begin : g_comb
         assign pulse_o = term;
      end
   endgenerate

   // R2
   ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < ratio_act);
   // R8
   ref_ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !term) |=> $stable(ratio_act));
   // R9
   ref_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ce) |=> $stable(cnt));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
   parameter int PRE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ce,
   input  logic mod_hi,
   output logic tick_o,
   output logic tick_q
);
   import psd_pkg::*;

   localparam int CW = $clog2(PRE + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] top;
   logic          wrap;
   psd_mod_e      mode;

   assign mode   = mod_hi ? PSD_MOD_HI : PSD_MOD_LO;
   assign top    = (mode == PSD_MOD_HI) ? CW'(PRE) : CW'(PRE - 1);
   assign wrap   = (cnt == top);
   assign tick_o = run && ce && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (ce) begin
         cnt <= wrap ? '0 : cnt + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= tick_o;
   end

   // R6
   pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= top);
   // R6
   pre_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q);
   // R9
   pre_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ce) |=> $stable(cnt));
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow #(
   parameter int NW      = 18,
   parameter int PRE     = 16,
   parameter int N_MIN   = 272,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic [NW-1:0] cfg_n,
   output logic          mod_hi,
   output logic          pulse_o
);
   localparam int PL = $clog2(PRE);
   localparam int AW = NW - PL;
   localparam logic [NW-1:0] NMIN_V = NW'(N_MIN);
   localparam logic [AW-1:0] A_RST  = NMIN_V[NW-1:PL];
   localparam logic [PL-1:0] B_RST  = NMIN_V[PL-1:0];

   logic [NW-1:0] n_eff;
   logic [AW-1:0] a_cfg, a_act, a_cnt;
   logic [PL-1:0] b_cfg, b_act, b_cnt;
   logic          last;
   logic          term;

   assign n_eff  = (cfg_n < NMIN_V) ? NMIN_V : cfg_n;
   assign a_cfg  = n_eff[NW-1:PL];
   assign b_cfg  = n_eff[PL-1:0];
   assign mod_hi = (b_cnt != b_act);
   assign last   = (a_cnt == a_act - AW'(1));
   assign term   = run && tick && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_cnt <= '0;
         b_cnt <= '0;
         a_act <= A_RST;
         b_act <= B_RST;
      end else if (!run) begin
         a_cnt <= '0;
         b_cnt <= '0;
         a_act <= a_cfg;
         b_act <= b_cfg;
      end else if (tick) begin
         if (last) begin
            a_cnt <= '0;
            b_cnt <= '0;
            a_act <= a_cfg;
            b_act <= b_cfg;
         end else begin
            a_cnt <= a_cnt + AW'(1);
            if (b_cnt != b_act) b_cnt <= b_cnt + PL'(1);
         end
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= term;
         end
         assign pulse_o = pulse_q;

         // R4
         main_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o |=> !pulse_o);
         // R7
         main_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o |-> $past(run));
      end else begin : g_comb
         assign pulse_o = term;
      end
   endgenerate

   // R4
   sw_a_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_cnt < a_act);
   // R6
   sw_b_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_cnt <= b_act);
   // R6
   sw_mode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(mod_hi));
   // R8
   sw_ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !term) |=> ($stable(a_act) && $stable(b_act)));
endmodule

// File: rtl/psdiv_pair.sv
module psdiv_pair #(
   parameter int PRE_DIV = psd_pkg::PSD_PRE_DIV,
   parameter int REF_W   = psd_pkg::PSD_REF_W,
   parameter int MAIN_W  = psd_pkg::PSD_MAIN_W,
   parameter int REF_MIN = psd_pkg::PSD_REF_MIN,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ref_ce,
   input  logic              fin_ce,
   input  logic [REF_W-1:0]  ref_ratio,
   input  logic [MAIN_W-1:0] main_ratio,
   output logic              ref_pulse,
   output logic              main_pulse,
   output logic              pre_out,
   output logic              mod_hi
);
   localparam int PRE_LOG2 = $clog2(PRE_DIV);
   localparam int N_MIN    = PRE_DIV * (PRE_DIV + 1);

   generate
      if (PRE_DIV < 2 || (1 << PRE_LOG2) != PRE_DIV) begin : g_bad_pre
         $error("PRE_DIV must be a power of two of at least 2");
      end
      if (REF_MIN < 2 || REF_W > 30 || REF_MIN >= (1 << REF_W)) begin : g_bad_ref
         $error("REF_MIN must be at least 2 and fit REF_W");
      end
      if (MAIN_W > 30 || N_MIN >= (1 << MAIN_W)) begin : g_bad_main
         $error("MAIN_W too narrow for the minimum main ratio");
      end
   endgenerate

   logic pre_tick;
   logic sel_hi;

   psd_refdiv #(
      .W         (REF_W),
      .MIN_RATIO (REF_MIN),
      .OUT_REG   (OUT_REG)
   ) u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .ce        (ref_ce),
      .cfg_ratio (ref_ratio),
      .pulse_o   (ref_pulse)
   );

   psd_prescaler #(
      .PRE (PRE_DIV)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .ce     (fin_ce),
      .mod_hi (sel_hi),
      .tick_o (pre_tick),
      .tick_q (pre_out)
   );

   psd_swallow #(
      .NW      (MAIN_W),
      .PRE     (PRE_DIV),
      .N_MIN   (N_MIN),
      .OUT_REG (OUT_REG)
   ) u_sw (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .tick    (pre_tick),
      .cfg_n   (main_ratio),
      .mod_hi  (sel_hi),
      .pulse_o (main_pulse)
   );

   assign mod_hi = sel_hi;

   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!ref_pulse && !main_pulse && !pre_out));
endmodule

// File: tb/psdiv_pair_tb.sv
`timescale 1ns/1ps
module psdiv_pair_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        ref_ce = 1'b1;
   logic        fin_ce = 1'b1;
   logic [16:0] ref_ratio = 17'd5;
   logic [17:0] main_ratio = 18'd272;
   logic        ref_pulse, main_pulse, pre_out, mod_hi;
   logic        ref_alt = 1'b0;
   logic        fin_alt = 1'b0;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   always @(negedge clk) begin
      ref_ce <= ref_alt ? ~ref_ce : 1'b1;
      fin_ce <= fin_alt ? ~fin_ce : 1'b1;
   end

   psdiv_pair u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .ref_ce     (ref_ce),
      .fin_ce     (fin_ce),
      .ref_ratio  (ref_ratio),
      .main_ratio (main_ratio),
      .ref_pulse  (ref_pulse),
      .main_pulse (main_pulse),
      .pre_out    (pre_out),
      .mod_hi     (mod_hi)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // sel 0 = ref_pulse, 1 = main_pulse; returns samples until pulse, -1 on timeout
   task automatic wait_pulse(input int sel, output int n);
      n = -1;
      for (int i = 1; i <= 20000; i++) begin
         @(negedge clk);
         if ((sel == 0 && ref_pulse) || (sel == 1 && main_pulse)) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic restart();
      @(negedge clk);
      run = 1'b0;
      repeat (2) @(negedge clk);
      run = 1'b1;
   endtask

   task automatic t_reset();
      check("R1 ref_pulse in reset", int'(ref_pulse), 0);
      check("R1 main_pulse in reset", int'(main_pulse), 0);
      check("R1 pre_out in reset", int'(pre_out), 0);
      check("R1 mod_hi in reset", int'(mod_hi), 0);
   endtask

   task automatic t_ref_basic(input int r);
      int n;
      ref_ratio = 17'(r);
      restart();
      wait_pulse(0, n);
      check($sformatf("R2 ref first pulse R=%0d", r), n, r);
      wait_pulse(0, n);
      check($sformatf("R2 ref period R=%0d", r), n, r);
   endtask

   task automatic t_ref_clamp(input int r);
      int n;
      ref_ratio = 17'(r);
      restart();
      wait_pulse(0, n);
      wait_pulse(0, n);
      check($sformatf("R3 ref clamp period cfg=%0d", r), n, 5);
   endtask

   task automatic t_main_basic(input int nr);
      int n;
      main_ratio = 18'(nr);
      restart();
      wait_pulse(1, n);
      check($sformatf("R4 main first pulse N=%0d", nr), n, nr);
      wait_pulse(1, n);
      check($sformatf("R4 main period N=%0d", nr), n, nr);
   endtask

   task automatic t_main_clamp(input int nr);
      int n;
      main_ratio = 18'(nr);
      restart();
      wait_pulse(1, n);
      check($sformatf("R5 main clamp first cfg=%0d", nr), n, 272);
   endtask

   task automatic t_swallow(input int nr);
      int hi_cnt = 0;
      int pre_cnt = 0;
      int last_hit = 0;
      main_ratio = 18'(nr);
      restart();
      for (int i = 1; i <= nr; i++) begin
         @(negedge clk);
         if (mod_hi) hi_cnt++;
         if (pre_out) pre_cnt++;
         if (i == nr) last_hit = int'(main_pulse);
      end
      check($sformatf("R6 div17 cycles N=%0d", nr), hi_cnt, 17 * (nr % 16));
      check($sformatf("R6 prescaler pulses N=%0d", nr), pre_cnt, nr / 16);
      check($sformatf("R6 main pulse at end N=%0d", nr), last_hit, 1);
   endtask

   task automatic t_power();
      int n;
      int seen = 0;
      ref_ratio = 17'd20;
      main_ratio = 18'd300;
      restart();
      repeat (150) @(negedge clk);
      run = 1'b0;
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (ref_pulse || main_pulse || pre_out) seen++;
      end
      check("R7 silent in power save", seen, 0);
      run = 1'b1;
      wait_pulse(0, n);
      check("R7 ref restart from zero", n, 20);
      restart();
      wait_pulse(1, n);
      check("R7 main restart from zero", n, 300);
      ref_ratio = 17'd300;
      restart();
      wait_pulse(0, n);
      check("R7 aligned first ref pulse", n, 300);
      check("R7 aligned main pulse same cycle", int'(main_pulse), 1);
   endtask

   task automatic t_ratio_change();
      int n;
      ref_ratio = 17'd5;
      restart();
      wait_pulse(0, n);
      ref_ratio = 17'd8;
      wait_pulse(0, n);
      check("R8 ref current period kept", n, 5);
      wait_pulse(0, n);
      check("R8 ref new ratio next period", n, 8);
      repeat (7) @(negedge clk);
      ref_ratio = 17'd11;
      wait_pulse(0, n);
      check("R8 ref pulse on time at collision", n, 1);
      wait_pulse(0, n);
      check("R8 ref collision ratio applied", n, 11);
      main_ratio = 18'd272;
      restart();
      wait_pulse(1, n);
      repeat (271) @(negedge clk);
      main_ratio = 18'd300;
      wait_pulse(1, n);
      check("R8 main pulse on time at collision", n, 1);
      wait_pulse(1, n);
      check("R8 main collision ratio applied", n, 300);
   endtask

   task automatic t_gaps();
      int n;
      ref_ratio = 17'd6;
      main_ratio = 18'd272;
      ref_alt = 1'b1;
      fin_alt = 1'b1;
      restart();
      wait_pulse(0, n);
      wait_pulse(0, n);
      check("R9 ref half-rate enable period", n, 12);
      wait_pulse(1, n);
      wait_pulse(1, n);
      check("R9 main half-rate enable period", n, 544);
      ref_alt = 1'b0;
      fin_alt = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_ref_basic(5);
      t_ref_basic(37);
      t_ref_clamp(2);
      t_ref_clamp(0);
      t_main_basic(272);
      t_main_basic(300);
      t_main_basic(4099);
      t_main_clamp(100);
      t_swallow(300);
      t_swallow(272);
      t_swallow(4099);
      t_power();
      t_ratio_change();
      t_gaps();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule